// File: doc/BRIEF.md
# Scalar Double-Precision Add Unit

This execution unit adds the low 64-bit lanes of two 128-bit vector operands as IEEE-754 binary64 numbers and builds a full 128-bit destination from that sum. The rounding direction is normally taken from a global mode input. In the masked three-operand form, an instruction may override it with its own field, but only when the second operand comes from a register. In that form, a single mask bit decides whether the low lane takes the sum, keeps its old contents, or is cleared. A masked-off lane also reports no exceptions.

The upper half of the result depends on the encoding form. The destructive two-operand form adds into the old destination and leaves everything above bit 63 untouched. The three-operand forms copy bits 127:64 from the first source and assert a flag that tells the register file to clear anything wider than 128 bits. Five exception flags come out with every result.

The unit has one register stage. An operation is presented together with `issue`, and its result appears on the outputs after the next rising clock edge. The outputs hold while `issue` is low.

Top module: `sdadd_unit`

## Requirements
- R1: With round-to-nearest-even, `result[63:0]` is the correctly rounded binary64 sum of the two addends, including cancellation that needs renormalisation. `exc_flags` bits are: bit0 invalid, bit1 denormal operand, bit2 overflow, bit3 underflow, bit4 inexact. Exact sums raise none of them.
- R2: The rounding code is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Each code rounds a non-exact sum in its own direction, including the sign of negative sums and ties to an even last bit. Any non-exact result raises inexact.
- R3: When `form` is 10 or 11 and both `static_rnd` and `src2_is_reg` are 1, `rnd_ctl` gives the rounding mode. In every other case `glob_rnd` gives it, including forms 00 and 01 with `static_rnd` set.
- R4: An exact zero sum of operands with opposite signs is -0 (0x8000000000000000) under toward-minus-infinity and +0 under every other mode.
- R5: On overflow, the result is infinity if the rounding direction moves away from zero for that sign (always under nearest-even). Otherwise it is the largest finite value of that sign. Overflow and inexact are raised together.
- R6: When an operand is a NaN, the result is that NaN with its quiet bit (bit 51) set, and the first addend's NaN is preferred. Invalid is raised only if a signalling NaN is present. Adding infinities of opposite sign gives 0xFFF8000000000000 and raises invalid. Infinity plus a finite value gives that infinity with no flags.
- R7: Denormal is raised when an operand is subnormal and neither operand is a NaN or an infinity. Underflow is raised only when the unrounded result is below the normal range and inexact, so an exact subnormal sum raises no underflow.
- R8: The mask inputs act only in forms 10 and 11. The low lane takes the sum when `mask_on` is 0 or `mask_bit` is 1. Otherwise it keeps `old_dst[63:0]` when `zero_mask` is 0 and becomes 0 when `zero_mask` is 1, and all five flags read 0.
- R9: In forms 01, 10 and 11, the first addend is `src1[63:0]`, `result[127:64]` equals `src1[127:64]` and `upper_zero` is 1. In form 00, the first addend is `old_dst[63:0]`, `result[127:64]` equals `old_dst[127:64]`, `upper_zero` is 0 and the mask inputs have no effect.
- R10: After reset, all outputs are 0. An operation presented with `issue` high appears on the outputs after the next rising edge, and the outputs do not change while `issue` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Load this cycle's operation into the output stage |
| form | input | 2 | Encoding form: 00 two-operand, 01 three-operand, 1x masked three-operand |
| src1 | input | 128 | First source vector |
| src2 | input | 128 | Second source vector (low lane used) |
| old_dst | input | 128 | Previous destination contents |
| static_rnd | input | 1 | Instruction requests its own rounding mode |
| src2_is_reg | input | 1 | Second source is a register, not memory |
| rnd_ctl | input | 2 | Instruction rounding mode |
| glob_rnd | input | 2 | Global rounding mode |
| mask_bit | input | 1 | Bit 0 of the write mask |
| mask_on | input | 1 | A write mask is present |
| zero_mask | input | 1 | Masked-off lane is cleared rather than merged |
| result | output | 128 | Destination vector |
| upper_zero | output | 1 | Destination bits above 127 must be cleared |
| exc_flags | output | 5 | Exception flags of the operation |

## Verification
The adder is exercised with patterns that each isolate one part of the datapath:
- Exact sums and a subtraction that needs a left renormalisation check alignment and normalisation.
- A half-ulp addend on an even and on an odd significand, positive and negative, separates the four rounding modes and the tie rule.
- Opposite-signed equal operands expose the sign rule for zero.
- The largest finite value doubled exercises both overflow outcomes.
- Quiet NaNs, signalling NaNs, opposing infinities and subnormals exercise the special-value and flag paths.

Separate operations toggle one control at a time to show which input picks the result: the static-rounding override against its register condition and form, the mask and zeroing bits, and the two-operand form. The unit is fed operands that would raise invalid while the lane is masked off, which shows that the flags are suppressed.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
  localparam int LANE_W = 64;
  localparam int VEC_W  = 128;
  localparam int NFLAG  = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } exc_t;
endpackage

// File: rtl/sdadd_rmode_sel.sv
module sdadd_rmode_sel
  import sdadd_pkg::*;
(
  input  logic [1:0] form_i,
  input  logic       static_i,
  input  logic       src2_reg_i,
  input  rmode_e     rc_i,
  input  rmode_e     glob_i,
  output rmode_e     rm_o
);
  // Override only exists in the masked three-operand forms.
  always_comb rm_o = (form_i[1] && static_i && src2_reg_i) ? rc_i : glob_i;
endmodule

// File: rtl/sdadd_fp_core.sv
module sdadd_fp_core
  import sdadd_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rmode_e       rm_i,
  output logic [W-1:0] sum_o,
  output exc_t         flags_o
);
  localparam int MW    = FRAC_W + 1;
  localparam int XW    = MW + 3;
  localparam int EW    = EXP_W + 2;
  localparam int EMAXV = (1 << EXP_W) - 1;

  function automatic logic [EW-1:0] lzc(input logic [XW-1:0] v);
    lzc = EW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) lzc = EW'(XW - 1 - i);
  endfunction

  logic [EXP_W-1:0]  ae, be, xe, ye;
  logic [FRAC_W-1:0] af, bf, xf, yf;
  logic              as, bs, xs, ys, swap, eff_sub, g, st, inc, to_inf;
  logic              a_nan, b_nan, a_inf, b_inf, a_sub, b_sub, a_snan, b_snan;
  logic [MW-1:0]     xm, ym;
  logic [EW-1:0]     xee, yee, dexp, dcl, lz, sh, ne, re;
  logic [2*XW-1:0]   wide;
  logic [XW-1:0]     ysh, nrm;
  logic [XW:0]       raw;
  logic [MW:0]       rmant;
  exc_t              f;

  assign {as, ae, af} = a_i;
  assign {bs, be, bf} = b_i;
  assign a_nan  = (&ae) & (|af);
  assign b_nan  = (&be) & (|bf);
  assign a_inf  = (&ae) & ~(|af);
  assign b_inf  = (&be) & ~(|bf);
  assign a_sub  = ~(|ae) & (|af);
  assign b_sub  = ~(|be) & (|bf);
  assign a_snan = a_nan & ~af[FRAC_W-1];
  assign b_snan = b_nan & ~bf[FRAC_W-1];

  always_comb begin
    // Order by magnitude so the aligned subtraction never goes negative.
    swap = b_i[W-2:0] > a_i[W-2:0];
    {xs, xe, xf} = swap ? b_i : a_i;
    {ys, ye, yf} = swap ? a_i : b_i;
    xm   = {|xe, xf};
    ym   = {|ye, yf};
    xee  = (xe == '0) ? EW'(1) : EW'(xe);
    yee  = (ye == '0) ? EW'(1) : EW'(ye);
    dexp = xee - yee;
    dcl  = (dexp > EW'(XW)) ? EW'(XW + 1) : dexp;
    wide = {ym, 3'b000, {XW{1'b0}}} >> dcl;
    ysh  = wide[2*XW-1:XW];
    ysh[0] = ysh[0] | (|wide[XW-1:0]);
    eff_sub = xs ^ ys;
    raw = eff_sub ? ({1'b0, xm, 3'b000} - {1'b0, ysh})
                  : ({1'b0, xm, 3'b000} + {1'b0, ysh});

    lz = lzc(raw[XW-1:0]);
    sh = '0;
    if (raw[XW]) begin
      nrm = {raw[XW:2], raw[1] | raw[0]};
      ne  = xee + EW'(1);
    end else begin
      sh  = (lz < xee - EW'(1)) ? lz : (xee - EW'(1));
      nrm = raw[XW-1:0] << sh;
      ne  = xee - sh;
    end

    g  = nrm[2];
    st = |nrm[1:0];
    unique case (rm_i)
      RM_NEAR: inc = g & (st | nrm[3]);
      RM_DOWN: inc = xs & (g | st);
      RM_UP:   inc = ~xs & (g | st);
      default: inc = 1'b0;
    endcase
    rmant = {1'b0, nrm[XW-1:3]} + {{MW{1'b0}}, inc};
    re    = ne;
    if (rmant[MW]) begin
      rmant = rmant >> 1;
      re    = ne + EW'(1);
    end

    f           = '0;
    f.inexact   = g | st;
    f.underflow = ~nrm[XW-1] & (g | st);
    f.denormal  = a_sub | b_sub;
    sum_o = {xs, rmant[MW-1] ? re[EXP_W-1:0] : {EXP_W{1'b0}}, rmant[FRAC_W-1:0]};

    if (rmant[MW-1] && re >= EW'(EMAXV)) begin
      to_inf     = (rm_i == RM_NEAR) || (rm_i == RM_UP && !xs) || (rm_i == RM_DOWN && xs);
      f.overflow = 1'b1;
      f.inexact  = 1'b1;
      sum_o = to_inf ? {xs, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                     : {xs, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else begin
      to_inf = 1'b0;
    end

    if (raw == '0) begin
      sum_o = {eff_sub ? (rm_i == RM_DOWN) : xs, {(W-1){1'b0}}};
      f     = '0;
      f.denormal = a_sub | b_sub;
    end

    if (a_inf || b_inf) begin
      f = '0;
      if (a_inf && b_inf && (as ^ bs)) begin
        sum_o     = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        f.invalid = 1'b1;
      end else begin
        sum_o = {a_inf ? as : bs, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
    end

    if (a_nan || b_nan) begin
      f         = '0;
      f.invalid = a_snan | b_snan;
      sum_o     = a_nan ? a_i : b_i;
      sum_o[FRAC_W-1] = 1'b1;
    end
    flags_o = f;
  end
endmodule

// File: rtl/sdadd_lane_build.sv
module sdadd_lane_build
  import sdadd_pkg::*;
(
  input  logic [1:0]        form_i,
  input  logic [LANE_W-1:0] sum_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [VEC_W-1:0]  src1_i,
  input  logic [VEC_W-1:0]  old_i,
  input  logic              mask_bit_i,
  input  logic              mask_on_i,
  input  logic              zero_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              upper_zero_o,
  output logic [NFLAG-1:0]  flags_o
);
  logic two_op, lane_on;

  always_comb begin
    two_op  = (form_i == 2'b00);
    lane_on = ~form_i[1] | ~mask_on_i | mask_bit_i;
    res_o[LANE_W-1:0] = lane_on ? sum_i
                      : (zero_i ? {LANE_W{1'b0}} : old_i[LANE_W-1:0]);
    res_o[VEC_W-1:LANE_W] = two_op ? old_i[VEC_W-1:LANE_W] : src1_i[VEC_W-1:LANE_W];
    upper_zero_o = ~two_op;
    flags_o      = lane_on ? flags_i : {NFLAG{1'b0}};
  end
endmodule

// File: rtl/sdadd_unit.sv
module sdadd_unit
  import sdadd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [1:0]     form,
  input  logic [127:0]   src1,
  input  logic [127:0]   src2,
  input  logic [127:0]   old_dst,
  input  logic           static_rnd,
  input  logic           src2_is_reg,
  input  logic [1:0]     rnd_ctl,
  input  logic [1:0]     glob_rnd,
  input  logic           mask_bit,
  input  logic           mask_on,
  input  logic           zero_mask,
  output logic [127:0]   result,
  output logic           upper_zero,
  output logic [4:0]     exc_flags
);
  localparam int SW = VEC_W + 1 + NFLAG;

  rmode_e            rm;
  logic [LANE_W-1:0] addend_a, sum;
  exc_t              core_flags;
  logic [VEC_W-1:0]  c_res;
  logic              c_uz;
  logic [NFLAG-1:0]  c_flags;

  assign addend_a = (form == 2'b00) ? old_dst[LANE_W-1:0] : src1[LANE_W-1:0];

  sdadd_rmode_sel u_rsel (
    .form_i(form), .static_i(static_rnd), .src2_reg_i(src2_is_reg),
    .rc_i(rmode_e'(rnd_ctl)), .glob_i(rmode_e'(glob_rnd)), .rm_o(rm)
  );

  sdadd_fp_core #(.EXP_W(11), .FRAC_W(52)) u_core (
    .a_i(addend_a), .b_i(src2[LANE_W-1:0]), .rm_i(rm),
    .sum_o(sum), .flags_o(core_flags)
  );

  sdadd_lane_build u_lane (
    .form_i(form), .sum_i(sum), .flags_i(core_flags), .src1_i(src1),
    .old_i(old_dst), .mask_bit_i(mask_bit), .mask_on_i(mask_on),
    .zero_i(zero_mask), .res_o(c_res), .upper_zero_o(c_uz), .flags_o(c_flags)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [SW-1:0] stage_q, stage_d;
      always_comb stage_d = issue ? {c_res, c_uz, c_flags} : stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
      end
      assign {result, upper_zero, exc_flags} = stage_q;
    end else begin : g_comb
      assign {result, upper_zero, exc_flags} = {c_res, c_uz, c_flags};
    end
  endgenerate
endmodule

// File: rtl/sdadd_unit_chk.sv
module sdadd_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [1:0]   form,
  input logic [127:0] src1,
  input logic [127:0] old_dst,
  input logic         mask_bit,
  input logic         mask_on,
  input logic         zero_mask,
  input logic [127:0] result,
  input logic         upper_zero,
  input logic [4:0]   exc_flags
);
  logic masked_off;
  assign masked_off = form[1] & mask_on & ~mask_bit;

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && masked_off && zero_mask |=> result[63:0] == 64'd0 && exc_flags == 5'd0);

  assert_merge_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && masked_off && !zero_mask |=> result[63:0] == $past(old_dst[63:0]) && exc_flags == 5'd0);

  assert_three_op_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue && form != 2'b00 |=> result[127:64] == $past(src1[127:64]) && upper_zero);

  assert_two_op_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue && form == 2'b00 |=> result[127:64] == $past(old_dst[127:64]) && !upper_zero);

  assert_ovf_inexact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flags[2] |-> exc_flags[4]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(result) && $stable(exc_flags) && $stable(upper_zero));
endmodule

bind sdadd_unit sdadd_unit_chk u_chk (.*);

// File: tb/sim_sdadd_unit.sv
`timescale 1ns/1ps
module sim_sdadd_unit;
  logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0;
  logic [1:0] form = 2'b01, rnd_ctl = 2'b00, glob_rnd = 2'b00;
  logic [127:0] src1 = '0, src2 = '0, old_dst = '0;
  logic static_rnd = 0, src2_is_reg = 0, mask_bit = 0, mask_on = 0, zero_mask = 0;
  logic [127:0] result;
  logic upper_zero;
  logic [4:0] exc_flags;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [63:0] S1U = 64'h1111_2222_3333_4444;
  localparam logic [63:0] S2U = 64'h5555_6666_7777_8888;
  localparam logic [63:0] DU  = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam logic [63:0] DLO = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ONE = 64'h3FF0000000000000, TWO = 64'h4000000000000000;
  localparam logic [63:0] THR = 64'h4008000000000000, HULP = 64'h3CA0000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000, NINF = 64'hFFF0000000000000;
  localparam logic [63:0] MAXF = 64'h7FEFFFFFFFFFFFFF, DQNAN = 64'hFFF8000000000000;

  always #10 clk = ~clk;

  sdadd_unit u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    form = f; src1 = {S1U, a}; src2 = {S2U, b}; old_dst = {DU, DLO}; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic add(input logic [63:0] a, input logic [63:0] b, input logic [1:0] rm,
                     input logic [63:0] er, input logic [4:0] ef, input string req);
    glob_rnd = rm;
    fire(2'b01, a, b);
    chk(req, result[63:0], er);
    chk(req, exc_flags, ef);
  endtask

  task automatic t_reset;
    chk("R10 reset result", result, '0);
    chk("R10 reset flags", {upper_zero, exc_flags}, '0);
  endtask

  task automatic t_basic;
    add(ONE, TWO, 2'b00, THR, 5'd0, "R1 1+2");
    add(THR, 64'hC000000000000000, 2'b00, ONE, 5'd0, "R1 3-2");
    add(ONE, 64'hBCA0000000000000, 2'b00, 64'h3FEFFFFFFFFFFFFF, 5'd0, "R1 1-half ulp");
  endtask

  task automatic t_round;
    add(ONE, HULP, 2'b00, ONE, 5'h10, "R2 near tie even");
    add(ONE, HULP, 2'b01, ONE, 5'h10, "R2 down");
    add(ONE, HULP, 2'b10, 64'h3FF0000000000001, 5'h10, "R2 up");
    add(ONE, HULP, 2'b11, ONE, 5'h10, "R2 zero");
    add(64'h3FF0000000000001, HULP, 2'b00, 64'h3FF0000000000002, 5'h10, "R2 near tie odd");
    add(64'hBFF0000000000000, 64'hBCA0000000000000, 2'b01, 64'hBFF0000000000001, 5'h10, "R2 neg down");
    add(64'hBFF0000000000000, 64'hBCA0000000000000, 2'b10, 64'hBFF0000000000000, 5'h10, "R2 neg up");
  endtask

  task automatic t_static;
    glob_rnd = 2'b00; rnd_ctl = 2'b10; static_rnd = 1; src2_is_reg = 1;
    fire(2'b10, ONE, HULP);
    chk("R3 static override", result[63:0], 64'h3FF0000000000001);
    src2_is_reg = 0;
    fire(2'b10, ONE, HULP);
    chk("R3 memory operand uses global", result[63:0], ONE);
    src2_is_reg = 1;
    fire(2'b01, ONE, HULP);
    chk("R3 unmasked form uses global", result[63:0], ONE);
    static_rnd = 0;
    fire(2'b11, ONE, HULP);
    chk("R3 no static bit uses global", result[63:0], ONE);
    src2_is_reg = 0;
  endtask

  task automatic t_zero;
    add(ONE, 64'hBFF0000000000000, 2'b00, 64'd0, 5'd0, "R4 +0 near");
    add(ONE, 64'hBFF0000000000000, 2'b01, 64'h8000000000000000, 5'd0, "R4 -0 down");
    add(ONE, 64'hBFF0000000000000, 2'b11, 64'd0, 5'd0, "R4 +0 zero");
  endtask

  task automatic t_ovf;
    add(MAXF, MAXF, 2'b00, PINF, 5'h14, "R5 near to inf");
    add(MAXF, MAXF, 2'b11, MAXF, 5'h14, "R5 zero to max");
    add(64'hFFEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'b10, 64'hFFEFFFFFFFFFFFFF, 5'h14, "R5 neg up");
    add(64'hFFEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'b01, NINF, 5'h14, "R5 neg down");
  endtask

  task automatic t_special;
    add(PINF, NINF, 2'b00, DQNAN, 5'h01, "R6 inf-inf");
    add(64'h7FF8000000000001, ONE, 2'b00, 64'h7FF8000000000001, 5'h00, "R6 qnan");
    add(64'h7FF0000000000001, ONE, 2'b00, 64'h7FF8000000000001, 5'h01, "R6 snan");
    add(ONE, 64'hFFF0000000000002, 2'b00, 64'hFFF8000000000002, 5'h01, "R6 snan second");
    add(NINF, ONE, 2'b00, NINF, 5'h00, "R6 inf+finite");
  endtask

  task automatic t_denorm;
    add(64'd1, 64'd1, 2'b00, 64'd2, 5'h02, "R7 subnormal sum");
    add(64'd1, 64'h8000000000000001, 2'b00, 64'd0, 5'h02, "R7 subnormal cancel");
  endtask

  task automatic t_mask;
    glob_rnd = 2'b00;
    mask_on = 1; mask_bit = 0; zero_mask = 0;
    fire(2'b10, PINF, NINF);
    chk("R8 merge keeps old", result[63:0], DLO);
    chk("R8 merge flags", exc_flags, 5'd0);
    zero_mask = 1;
    fire(2'b10, PINF, NINF);
    chk("R8 zeroing", result[63:0], 64'd0);
    chk("R8 zeroing flags", exc_flags, 5'd0);
    mask_bit = 1;
    fire(2'b11, PINF, NINF);
    chk("R8 lane enabled", {result[63:0], exc_flags}, {DQNAN, 5'h01});
    mask_on = 0; mask_bit = 0;
    fire(2'b10, ONE, TWO);
    chk("R8 no mask", result[63:0], THR);
    mask_on = 1;
    fire(2'b01, ONE, TWO);
    chk("R8 unmasked form ignores mask", result[63:0], THR);
    chk("R9 three-op upper", {result[127:64], upper_zero}, {S1U, 1'b1});
    mask_on = 0; zero_mask = 0;
  endtask

  task automatic t_two_op;
    @(negedge clk);
    form = 2'b00; src1 = {S1U, 64'h4014000000000000}; src2 = {S2U, TWO};
    old_dst = {DU, ONE}; mask_on = 1; mask_bit = 0; zero_mask = 1; issue = 1;
    @(negedge clk);
    issue = 0;
    chk("R9 two-op sum from old dest", result[63:0], THR);
    chk("R9 two-op upper kept", {result[127:64], upper_zero}, {DU, 1'b0});
    mask_on = 0; zero_mask = 0;
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    fire(2'b01, ONE, TWO);
    keep = result;
    @(negedge clk);
    src1 = '1; src2 = '0; form = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold without issue", result, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_round();
    t_static();
    t_zero();
    t_ovf();
    t_special();
    t_denorm();
    t_mask();
    t_two_op();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule